// File: doc/BRIEF.md
# Serial Link Initialization Controller

This block is the link-level controller of a point-to-point serial link that carries data and strobe lines. It brings the link up through a fixed sequence of phases and tears it down again when something goes wrong. First the receiver is held in reset for a silent period. Then the receiver is enabled and the block waits for a further settling period. From that point the link can be started. Once started, the transmitter sends NULL tokens until the peer's NULL is seen. The transmitter then sends flow-control tokens (FCTs) until the peer's first FCT arrives, which puts the link in normal operation. The block does no bit-level coding. It exchanges one-cycle event pulses with the receiver and enables and requests with the transmitter.

In normal operation the block keeps two credit counts. The outgoing count is the number of characters the peer has agreed to accept. The incoming count is the number of receive-buffer slots already announced to the peer. It asks the transmitter for a new FCT whenever at least eight free slots have not yet been announced. Any line error, an over-announced credit, or a disable request sends the link back to the reset phase. When the cause is an error, a flag is raised for exactly one cycle.

All timing comes from the `CLK_HZ` parameter. The reset phase lasts 6.4 us, which is `CLK_HZ/156250` cycles. The settling wait, the Started timeout and the Connecting timeout each last 12.8 us, which is `CLK_HZ/78125` cycles.

Top module: `dsl_link_ctrl`

## Requirements
- R1: While `rst_n` is low, and for exactly RST_CYC rising edges after it is released, `rx_enable` is 0, `rx_reset` is 1, and `tx_on`, `fct_pend`, `tx_ready`, all state outputs and all flags are 0. The block then waits TMO_CYC edges before it becomes ready, so with `start_req` held high `st_started` rises on edge RST_CYC+TMO_CYC+1 after release.
- R2: When the block is ready, `start_req` moves it to Started on the next edge, provided `link_off` is low. While `link_off` is high the link never starts.
- R3: With `auto_start` high and `start_req` low, the ready link stays idle until `rx_null` is pulsed. `st_started` then rises on the second edge after the pulse and `st_connecting` on the third.
- R4: If Started lasts TMO_CYC edges with no NULL received, the link returns to the reset phase (`rx_enable` 0) with every flag at 0.
- R5: An `rx_null` pulse in Started makes `st_connecting` 1 on the next edge. If Connecting then lasts TMO_CYC edges with no FCT, the link returns to reset with no flag.
- R6: An `rx_fct` pulse in Connecting gives `st_running` 1 on the next edge, with 8 units of outgoing credit, so `tx_ready` is 1.
- R7: An `rx_char` or `rx_time` pulse in Connecting returns the link to reset on the next edge with no flag.
- R8: In Run, a pulse on `err_disc`, `err_par` or `err_esc` tears the link down on the next edge. The matching flag (`flag_disc`, `flag_par` or `flag_esc` respectively) is 1 for that single cycle, and the other flags stay 0.
- R9: `link_off` high in Run ends Run on the next edge with no flag.
- R10: Each `rx_fct` in Run adds 8 units of outgoing credit, up to 56. Each edge with `tx_write` and `tx_ready` both high uses one unit. `tx_ready` is 1 only in Run with nonzero credit, so seven FCTs allow exactly 56 writes.
- R11: An `rx_fct` that arrives while outgoing credit exceeds 48 is a credit error. On the next edge the link tears down and `flag_cred` is 1 for one cycle.
- R12: In Connecting and Run, `fct_pend` is 1 exactly when `rx_room` ≥ A+8 and A+8 ≤ 56, where A is the announced count. A grows by 8 on each `fct_sent` edge while `fct_pend` is high. A shrinks by 1 on each `rx_char` in Run while A>0. A is 0 outside Connecting and Run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Request to start the link |
| auto_start | input | 1 | Start once the first NULL has been received |
| link_off | input | 1 | Disable request; blocks start and tears the link down |
| rx_null | input | 1 | Receiver pulse: NULL received |
| rx_fct | input | 1 | Receiver pulse: FCT received |
| rx_char | input | 1 | Receiver pulse: data character or end-of-packet marker received |
| rx_time | input | 1 | Receiver pulse: time code received |
| err_disc | input | 1 | Receiver pulse: disconnect detected |
| err_par | input | 1 | Receiver pulse: parity error |
| err_esc | input | 1 | Receiver pulse: escape sequence error |
| rx_room | input | ROOM_W | Free slots in the receive buffer |
| fct_sent | input | 1 | Transmitter pulse: one FCT sent |
| tx_write | input | 1 | User offers a character for sending |
| tx_ready | output | 1 | Character accepted on this edge when `tx_write` is high |
| tx_on | output | 1 | Transmitter enabled (Started, Connecting, Run) |
| fct_pend | output | 1 | Transmitter should send one FCT |
| rx_enable | output | 1 | Receiver enabled |
| rx_reset | output | 1 | Receiver held in reset |
| st_started | output | 1 | Link is in Started |
| st_connecting | output | 1 | Link is in Connecting |
| st_running | output | 1 | Link is in Run |
| flag_disc | output | 1 | One-cycle disconnect teardown flag |
| flag_par | output | 1 | One-cycle parity teardown flag |
| flag_esc | output | 1 | One-cycle escape teardown flag |
| flag_cred | output | 1 | One-cycle credit teardown flag |

## Verification
The bench uses `CLK_HZ` of 5 MHz, so the phases last 32 and 64 cycles. It counts edges between events, which pins every phase length exactly; a timeout that is one cycle off shows up as a count mismatch. Teardown is tried with each error kind, with both kinds of unexpected character, and with a disable request. Each case checks that only the matching flag rises, which separates a swapped or missing flag from a correct one. Credit is driven to its ceiling and drained by repeated writes, and one FCT past the ceiling is sent. The announced count is stepped through receive-room values that lie just on either side of the threshold and up to its cap, so an off-by-one comparison or a missing cap changes the number of requested FCTs.

// File: rtl/dsl_link_pkg.sv
package dsl_link_pkg;

    typedef enum logic [2:0] {
        LS_ERRRST  = 3'd0,
        LS_ERRWAIT = 3'd1,
        LS_READY   = 3'd2,
        LS_STARTED = 3'd3,
        LS_CONNECT = 3'd4,
        LS_RUN     = 3'd5
    } link_state_e;

    typedef struct packed {
        link_state_e state;
        logic        null_seen;
        logic        fl_disc;
        logic        fl_par;
        logic        fl_esc;
        logic        fl_cred;
    } link_ctl_t;

endpackage

// File: rtl/dsl_link_timer.sv
module dsl_link_timer #(
    parameter int RST_CYC = 32,
    parameter int TMO_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic rst_done,
    output logic tmo_hit
);
    localparam int TW = $clog2(TMO_CYC + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (cnt_q != TW'(TMO_CYC - 1)) begin
            cnt_d = cnt_q + TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign rst_done = (cnt_q == TW'(RST_CYC - 1));
    assign tmo_hit  = (cnt_q == TW'(TMO_CYC - 1));

endmodule

// File: rtl/dsl_link_txcred.sv
module dsl_link_txcred #(
    parameter int CRED_MAX  = 56,
    parameter int CRED_STEP = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic add,
    input  logic take,
    output logic cred_nz,
    output logic over
);
    localparam int CW = $clog2(CRED_MAX + 1);

    logic [CW-1:0] cred_d, cred_q;

    always_comb begin
        cred_d = cred_q;
        if (!active) begin
            cred_d = '0;
        end else begin
            if (add && !over) cred_d = cred_d + CW'(CRED_STEP);
            if (take)         cred_d = cred_d - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cred_q <= '0;
        else        cred_q <= cred_d;
    end

    assign cred_nz = (cred_q != '0);
    assign over    = (cred_q > CW'(CRED_MAX - CRED_STEP));

endmodule

// File: rtl/dsl_link_rxcred.sv
module dsl_link_rxcred #(
    parameter int CRED_MAX  = 56,
    parameter int CRED_STEP = 8,
    parameter int ROOM_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              sent,
    input  logic              got,
    input  logic [ROOM_W-1:0] room,
    output logic              pend
);
    localparam int CW = $clog2(CRED_MAX + 1);
    localparam int XW = ((ROOM_W > CW) ? ROOM_W : CW) + 1;

    logic [CW-1:0] ann_d, ann_q;
    logic [XW-1:0] ann_next;

    assign ann_next = XW'(ann_q) + XW'(CRED_STEP);
    assign pend     = active && (ann_next <= XW'(CRED_MAX)) && (XW'(room) >= ann_next);

    always_comb begin
        ann_d = ann_q;
        if (!active) begin
            ann_d = '0;
        end else begin
            if (sent && pend)           ann_d = ann_d + CW'(CRED_STEP);
            if (got && (ann_q != '0))   ann_d = ann_d - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ann_q <= '0;
        else        ann_q <= ann_d;
    end

endmodule

// File: rtl/dsl_link_ctrl.sv
module dsl_link_ctrl
    import dsl_link_pkg::*;
#(
    parameter int CLK_HZ    = 20_000_000,
    parameter int CRED_MAX  = 56,
    parameter int CRED_STEP = 8,
    parameter int ROOM_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              auto_start,
    input  logic              link_off,
    input  logic              rx_null,
    input  logic              rx_fct,
    input  logic              rx_char,
    input  logic              rx_time,
    input  logic              err_disc,
    input  logic              err_par,
    input  logic              err_esc,
    input  logic [ROOM_W-1:0] rx_room,
    input  logic              fct_sent,
    input  logic              tx_write,
    output logic              tx_ready,
    output logic              tx_on,
    output logic              fct_pend,
    output logic              rx_enable,
    output logic              rx_reset,
    output logic              st_started,
    output logic              st_connecting,
    output logic              st_running,
    output logic              flag_disc,
    output logic              flag_par,
    output logic              flag_esc,
    output logic              flag_cred
);
    // 6.4 us and 12.8 us expressed in clock cycles
    localparam int RST_CYC = CLK_HZ / 156250;
    localparam int TMO_CYC = CLK_HZ / 78125;

    link_ctl_t ctl_d, ctl_q;

    logic rst_done, tmo_hit, restart;
    logic cred_nz, cred_over, cred_active;
    logic line_err, stray_rx;

    assign line_err    = err_disc | err_par | err_esc;
    assign stray_rx    = rx_fct | rx_char | rx_time;
    assign cred_active = (ctl_q.state == LS_CONNECT) || (ctl_q.state == LS_RUN);
    assign restart     = (ctl_d.state != ctl_q.state);

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.fl_disc = 1'b0;
        ctl_d.fl_par  = 1'b0;
        ctl_d.fl_esc  = 1'b0;
        ctl_d.fl_cred = 1'b0;
        ctl_d.null_seen = (ctl_q.state != LS_ERRRST) && (ctl_q.null_seen || rx_null);

        unique case (ctl_q.state)
            LS_ERRRST: begin
                if (rst_done) ctl_d.state = LS_ERRWAIT;
            end
            LS_ERRWAIT: begin
                if (line_err || (ctl_q.null_seen && stray_rx)) ctl_d.state = LS_ERRRST;
                else if (tmo_hit)                              ctl_d.state = LS_READY;
            end
            LS_READY: begin
                if (line_err || (ctl_q.null_seen && stray_rx))
                    ctl_d.state = LS_ERRRST;
                else if (!link_off && (start_req || (auto_start && ctl_q.null_seen)))
                    ctl_d.state = LS_STARTED;
            end
            LS_STARTED: begin
                if (link_off || line_err || tmo_hit || (ctl_q.null_seen && stray_rx))
                    ctl_d.state = LS_ERRRST;
                else if (ctl_q.null_seen || rx_null)
                    ctl_d.state = LS_CONNECT;
            end
            LS_CONNECT: begin
                if (link_off || line_err || tmo_hit || rx_char || rx_time)
                    ctl_d.state = LS_ERRRST;
                else if (rx_fct)
                    ctl_d.state = LS_RUN;
            end
            LS_RUN: begin
                ctl_d.fl_disc = err_disc;
                ctl_d.fl_par  = err_par;
                ctl_d.fl_esc  = err_esc;
                ctl_d.fl_cred = rx_fct && cred_over;
                if (link_off || line_err || (rx_fct && cred_over))
                    ctl_d.state = LS_ERRRST;
            end
            default: ctl_d.state = LS_ERRRST;
        endcase

        if (ctl_d.state == LS_ERRRST) ctl_d.null_seen = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: LS_ERRRST, null_seen: 1'b0, fl_disc: 1'b0,
                       fl_par: 1'b0, fl_esc: 1'b0, fl_cred: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    dsl_link_timer #(
        .RST_CYC (RST_CYC),
        .TMO_CYC (TMO_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .rst_done (rst_done),
        .tmo_hit  (tmo_hit)
    );

    dsl_link_txcred #(
        .CRED_MAX  (CRED_MAX),
        .CRED_STEP (CRED_STEP)
    ) u_txcred (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (cred_active),
        .add     (rx_fct),
        .take    (tx_write && tx_ready),
        .cred_nz (cred_nz),
        .over    (cred_over)
    );

    dsl_link_rxcred #(
        .CRED_MAX  (CRED_MAX),
        .CRED_STEP (CRED_STEP),
        .ROOM_W    (ROOM_W)
    ) u_rxcred (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (cred_active),
        .sent   (fct_sent),
        .got    (rx_char && (ctl_q.state == LS_RUN)),
        .room   (rx_room),
        .pend   (fct_pend)
    );

    assign st_started    = (ctl_q.state == LS_STARTED);
    assign st_connecting = (ctl_q.state == LS_CONNECT);
    assign st_running    = (ctl_q.state == LS_RUN);
    assign tx_on         = st_started || st_connecting || st_running;
    assign tx_ready      = st_running && cred_nz;
    assign rx_enable     = (ctl_q.state != LS_ERRRST);
    assign rx_reset      = !rx_enable;
    assign flag_disc     = ctl_q.fl_disc;
    assign flag_par      = ctl_q.fl_par;
    assign flag_esc      = ctl_q.fl_esc;
    assign flag_cred     = ctl_q.fl_cred;

endmodule

// File: rtl/dsl_link_ctrl_chk.sv
module dsl_link_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic link_off,
    input logic rx_fct,
    input logic tx_ready,
    input logic tx_on,
    input logic fct_pend,
    input logic rx_enable,
    input logic st_started,
    input logic st_connecting,
    input logic st_running,
    input logic flag_disc,
    input logic flag_par,
    input logic flag_esc,
    input logic flag_cred
);
    logic fl_any;
    assign fl_any = flag_disc | flag_par | flag_esc | flag_cred;

    AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |-> (!tx_on && !fct_pend && !tx_ready)); // R1

    AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_started, st_connecting, st_running})); // R6

    AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_running) |-> ($past(st_connecting) && $past(rx_fct))); // R6

    AST_FLAG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fl_any |=> !fl_any); // R8

    AST_FLAG_TEARDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        fl_any |-> (!rx_enable && !st_running)); // R8

    AST_OFF_LEAVES_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_running && link_off) |=> !st_running); // R9

    AST_READY_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> st_running); // R10

    AST_PEND_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        fct_pend |-> (st_connecting || st_running)); // R12

endmodule

bind dsl_link_ctrl dsl_link_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .link_off      (link_off),
    .rx_fct        (rx_fct),
    .tx_ready      (tx_ready),
    .tx_on         (tx_on),
    .fct_pend      (fct_pend),
    .rx_enable     (rx_enable),
    .st_started    (st_started),
    .st_connecting (st_connecting),
    .st_running    (st_running),
    .flag_disc     (flag_disc),
    .flag_par      (flag_par),
    .flag_esc      (flag_esc),
    .flag_cred     (flag_cred)
);

// File: tb/sim_dsl_link_ctrl.sv
module sim_dsl_link_ctrl;
    localparam int CLK_HZ = 5_000_000;
    localparam int RSTC   = CLK_HZ / 156250;
    localparam int TMOC   = CLK_HZ / 78125;

    logic clk = 1'b0;
    logic rst_n, start_req, auto_start, link_off;
    logic rx_null, rx_fct, rx_char, rx_time, err_disc, err_par, err_esc;
    logic [5:0] rx_room;
    logic fct_sent, tx_write;
    logic tx_ready, tx_on, fct_pend, rx_enable, rx_reset;
    logic st_started, st_connecting, st_running;
    logic flag_disc, flag_par, flag_esc, flag_cred;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dsl_link_ctrl #(.CLK_HZ(CLK_HZ)) u0 (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .auto_start(auto_start),
        .link_off(link_off), .rx_null(rx_null), .rx_fct(rx_fct), .rx_char(rx_char),
        .rx_time(rx_time), .err_disc(err_disc), .err_par(err_par), .err_esc(err_esc),
        .rx_room(rx_room), .fct_sent(fct_sent), .tx_write(tx_write),
        .tx_ready(tx_ready), .tx_on(tx_on), .fct_pend(fct_pend),
        .rx_enable(rx_enable), .rx_reset(rx_reset), .st_started(st_started),
        .st_connecting(st_connecting), .st_running(st_running),
        .flag_disc(flag_disc), .flag_par(flag_par), .flag_esc(flag_esc),
        .flag_cred(flag_cred)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int flags();
        return {flag_disc, flag_par, flag_esc, flag_cred};
    endfunction

    task automatic pulse(input int which);
        case (which)
            0: rx_null  = 1'b1;
            1: rx_fct   = 1'b1;
            2: rx_char  = 1'b1;
            3: rx_time  = 1'b1;
            4: err_disc = 1'b1;
            5: err_par  = 1'b1;
            6: err_esc  = 1'b1;
            7: fct_sent = 1'b1;
            default: link_off = 1'b1;
        endcase
        @(negedge clk);
        {rx_null, rx_fct, rx_char, rx_time, err_disc, err_par, err_esc, fct_sent, link_off} = '0;
    endtask

    task automatic go_start();
        int n = 0;
        start_req = 1'b1;
        while (!st_started && n < 400) begin @(negedge clk); n++; end
        start_req = 1'b0;
        check(st_started == 1'b1, "R2 start", int'(st_started), 1);
    endtask

    task automatic go_connect();
        go_start();
        pulse(0);
        check(st_connecting == 1'b1, "R5 null to connecting", int'(st_connecting), 1);
    endtask

    task automatic go_run();
        go_connect();
        pulse(1);
        check(st_running && tx_ready, "R6 fct to run", int'({st_running, tx_ready}), 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        rst_n = 1'b0; start_req = 1'b0; auto_start = 1'b0; link_off = 1'b0;
        {rx_null, rx_fct, rx_char, rx_time, err_disc, err_par, err_esc, fct_sent} = '0;
        rx_room = '0; tx_write = 1'b0;
        cyc(3);
        // R1 reset state
        check({rx_enable, tx_on, fct_pend, tx_ready, st_started, st_connecting, st_running} == 0
              && rx_reset && flags() == 0, "R1 reset outputs", int'(rx_enable), 0);

        // R1 phase lengths, R4 started timeout
        rst_n = 1'b1; start_req = 1'b1;
        n = 0;
        while (!rx_enable && n < 500) begin @(negedge clk); n++; end
        check(n == RSTC, "R1 reset phase length", n, RSTC);
        check(!tx_on && !st_started, "R1 quiet during wait", int'(tx_on), 0);
        while (!st_started && n < 500) begin @(negedge clk); n++; end
        check(n == RSTC + TMOC + 1, "R1 start edge", n, RSTC + TMOC + 1);
        start_req = 1'b0;
        n = 0;
        while (st_started && n < 500) begin @(negedge clk); n++; end
        check(n == TMOC, "R4 started timeout", n, TMOC);
        check(!rx_enable && flags() == 0, "R4 no flag", flags(), 0);

        // R2 disable blocks start
        link_off = 1'b1;
        cyc(200);
        check(!st_started, "R2 link_off blocks", int'(st_started), 0);
        link_off = 1'b0; start_req = 1'b1;
        cyc(1);
        check(st_started, "R2 start from ready", int'(st_started), 1);
        start_req = 1'b0;

        // R5 connecting timeout
        pulse(0);
        check(st_connecting && tx_on, "R5 connecting", int'(st_connecting), 1);
        n = 0;
        while (st_connecting && n < 500) begin @(negedge clk); n++; end
        check(n == TMOC, "R5 connecting timeout", n, TMOC);
        check(flags() == 0 && !rx_enable, "R5 no flag", flags(), 0);

        // R7 unexpected characters in Connecting
        for (int k = 2; k <= 3; k++) begin
            go_connect();
            pulse(k);
            check(!st_connecting && !rx_enable && flags() == 0, "R7 unexpected char",
                  int'({st_connecting, rx_enable}), 0);
        end

        // R10 credit fill and drain, R11 credit error
        go_run();
        for (int k = 0; k < 6; k++) pulse(1);
        check(st_running && flags() == 0, "R10 fill to 56 ok", flags(), 0);
        tx_write = 1'b1;
        n = 0;
        while (tx_ready && n < 100) begin @(negedge clk); n++; end
        tx_write = 1'b0;
        check(n == 56, "R10 writes accepted", n, 56);
        check(st_running && !tx_ready, "R10 ready low at zero", int'(tx_ready), 0);
        for (int k = 0; k < 7; k++) pulse(1);
        check(tx_ready && st_running, "R10 refill", int'(tx_ready), 1);
        pulse(1);
        check(flag_cred && !st_running, "R11 credit error", flags(), 1);
        cyc(1);
        check(!flag_cred, "R11 flag one cycle", int'(flag_cred), 0);

        // R8 each line error in Run
        for (int k = 4; k <= 6; k++) begin
            go_run();
            pulse(k);
            check(flags() == (1 << (7 - k)) && !st_running, "R8 error flag", flags(), 1 << (7 - k));
            cyc(1);
            check(flags() == 0, "R8 flag one cycle", flags(), 0);
        end

        // R9 disable in Run
        go_run();
        pulse(8);
        check(!st_running && flags() == 0, "R9 link_off", int'(st_running), 0);

        // R12 FCT requests against receive room
        rx_room = 6'd20;
        go_connect();
        check(fct_pend, "R12 pend 0/20", int'(fct_pend), 1);
        pulse(7);
        check(fct_pend, "R12 pend 8/20", int'(fct_pend), 1);
        pulse(7);
        check(!fct_pend, "R12 no pend 16/20", int'(fct_pend), 0);
        pulse(1);
        for (int k = 0; k < 5; k++) pulse(2);
        check(st_running && fct_pend, "R12 pend 11/20", int'(fct_pend), 1);
        pulse(7);
        check(!fct_pend, "R12 no pend 19/20", int'(fct_pend), 0);
        rx_room = 6'd27;
        cyc(1);
        check(fct_pend, "R12 pend 19/27", int'(fct_pend), 1);
        rx_room = 6'd63;
        n = 0;
        while (fct_pend && n < 20) begin pulse(7); n++; end
        check(n == (56 - 19) / 8, "R12 capped sends", n, (56 - 19) / 8);
        pulse(8);
        rx_room = '0;

        // R3 autostart
        auto_start = 1'b1;
        cyc(200);
        check(!st_started, "R3 no start without null", int'(st_started), 0);
        pulse(0);
        check(!st_started, "R3 not yet", int'(st_started), 0);
        cyc(1);
        check(st_started, "R3 started", int'(st_started), 1);
        cyc(1);
        check(st_connecting, "R3 connecting", int'(st_connecting), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule